// File: doc/BRIEF.md
# Four-Mode Barrel Shifter

This block moves a 16-bit operand by 0 to 15 bit positions in one of four ways. A 2-bit mode code selects the operation: rotate left, logical shift left, arithmetic shift right or logical shift right. The result is purely combinational. It has no clock and no state, and the output follows the current operand, amount and mode.

The shifter is a logarithmic network of four cascaded stages. The stages move the data by 1, 2, 4 and 8 positions, and each stage is enabled by the matching bit of the amount. A datapath such as an ALU uses it as its shift unit. In arithmetic-right mode, every stage takes its fill bit from the sign of the original operand, never from an intermediate stage.

Top module: `barrel_shift16`

## Requirements
- R1: Mode code 2'b00 rotates left: result bit (i+n) mod 16 equals operand bit i, so bits leaving bit 15 re-enter at bit 0.
- R2: Mode code 2'b01 shifts left logically: result bit i equals operand bit i-n for i >= n, and the n lowest result bits are zero.
- R3: Mode code 2'b10 shifts right arithmetically: result bit i equals operand bit i+n for i+n <= 15, and the n highest result bits equal operand bit 15, for every amount including 15.
- R4: Mode code 2'b11 shifts right logically: result bit i equals operand bit i+n for i+n <= 15, and the n highest result bits are zero.
- R5: An amount of zero returns the operand unchanged in every mode.
- R6: The result depends only on the present inputs: a change of operand, amount or mode appears at the output without any clock edge.
- R7: Every amount from 0 to 15 is honoured in every mode, including amounts that combine several of the 1, 2, 4 and 8 stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 16 | Value to be shifted or rotated |
| amount_i | input | 4 | Number of bit positions, 0 to 15 |
| mode_i | input | 2 | 00 rotate left, 01 shift left, 10 arithmetic right, 11 logical right |
| result_o | output | 16 | Shifted or rotated value |

## Verification
Each mode is swept over all sixteen amounts with a set of operands. With an all-ones operand, a wrong fill shows as a missing one. A lone bit 15 or bit 0 shows where bits wrap or fall off. The mixed patterns 16'hA5C3 and 16'h7FFE show when the arithmetic fill takes an intermediate bit instead of the original sign. A zero-amount sweep, a zero operand and changes of the inputs between clock edges cover the pass-through case and the combinational behaviour.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    MODE_ROTL = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_ASR  = 2'b10,
    MODE_LSR  = 2'b11
  } shf_mode_e;
endpackage

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] dout_o
);
  logic             rotate;
  logic [WIDTH-1:0] left_v;
  logic [WIDTH-1:0] right_v;

  assign rotate = (mode_i == MODE_ROTL);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i >= DIST) begin : g_lin
      assign left_v[i] = din_i[i-DIST];
    end else begin : g_lwrap
      assign left_v[i] = rotate & din_i[WIDTH-DIST+i];
    end
    if (i + DIST < WIDTH) begin : g_rin
      assign right_v[i] = din_i[i+DIST];
    end else begin : g_rfill
      assign right_v[i] = fill_i;
    end
  end

  always_comb begin
    if (!en_i)          dout_o = din_i;
    else if (mode_i[1]) dout_o = right_v;
    else                dout_o = left_v;
  end
endmodule

// File: rtl/barrel_shift16.sv
module barrel_shift16
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] stage_d [AMT_W+1];
  logic             sign_fill;

  // Fill comes from the original operand for every stage.
  assign sign_fill  = (mode_i == MODE_ASR) & operand_i[WIDTH-1];
  assign stage_d[0] = operand_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shf_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .din_i  (stage_d[k]),
      .en_i   (amount_i[k]),
      .mode_i (mode_i),
      .fill_i (sign_fill),
      .dout_o (stage_d[k+1])
    );
  end

  assign result_o = stage_d[AMT_W];

  always_comb begin
    if (mode_i == MODE_ROTL)
      a_r1_rotate_keeps_ones: assert ($countones(result_o) == $countones(operand_i));
    if (mode_i == MODE_SHL && amount_i != '0)
      a_r2_shl_low_zero: assert (result_o[0] == 1'b0);
    if (mode_i == MODE_ASR)
      a_r3_asr_sign_kept: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    if (mode_i == MODE_LSR && amount_i != '0)
      a_r4_lsr_high_zero: assert (result_o[WIDTH-1] == 1'b0);
    if (amount_i == '0)
      a_r5_zero_passthru: assert (result_o == operand_i);
  end
endmodule

// File: tb/barrel_shift16_test.sv
module barrel_shift16_test;
  logic        clk;
  logic [15:0] operand;
  logic [3:0]  amount;
  logic [1:0]  mode;
  logic [15:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  barrel_shift16 uut (
    .operand_i(operand), .amount_i(amount), .mode_i(mode), .result_o(result)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ref_model(input logic [15:0] v, input int n, input logic [1:0] m);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      case (m)
        2'b00: r[(i + n) % 16] = v[i];
        2'b01: r[i] = (i >= n) ? v[i-n] : 1'b0;
        2'b10: r[i] = (i + n <= 15) ? v[i+n] : v[15];
        default: r[i] = (i + n <= 15) ? v[i+n] : 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s mode=%b amt=%0d op=%h actual=%h expected=%h",
               req, mode, amount, operand, result, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v, input int n, input logic [1:0] m);
    @(negedge clk);
    operand = v; amount = n[3:0]; mode = m;
    #1;
  endtask

  localparam int NPAT = 7;
  logic [15:0] pats [NPAT] = '{16'hFFFF, 16'h8000, 16'h0001, 16'hA5C3, 16'h7FFE, 16'h8001, 16'h1234};

  task automatic sweep_mode(input logic [1:0] m, input string req);
    for (int p = 0; p < NPAT; p++)
      for (int n = 0; n < 16; n++) begin
        apply(pats[p], n, m);
        check(req, ref_model(pats[p], n, m));
      end
  endtask

  task automatic test_zero_operand;
    for (int m = 0; m < 4; m++) begin
      apply(16'h0000, 15, m[1:0]);
      check("R7", 16'h0000);
    end
  endtask

  task automatic test_zero_amount;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < NPAT; p++) begin
        apply(pats[p], 0, m[1:0]);
        check("R5", pats[p]);
      end
  endtask

  task automatic test_asr_corners;
    apply(16'h8000, 15, 2'b10); check("R3", 16'hFFFF);
    apply(16'h7FFF, 15, 2'b10); check("R3", 16'h0000);
    apply(16'hC000, 7, 2'b10);  check("R3", 16'hFF80);
    apply(16'h8000, 15, 2'b11); check("R4", 16'h0001);
    apply(16'h8000, 1, 2'b00);  check("R1", 16'h0001);
    apply(16'h8000, 1, 2'b01);  check("R2", 16'h0000);
  endtask

  task automatic test_comb;
    @(posedge clk); #2;
    operand = 16'h00F0; amount = 4'd4; mode = 2'b01; #1;
    check("R6", 16'h0F00);
    mode = 2'b11; #1;
    check("R6", 16'h000F);
    amount = 4'd3; #1;
    check("R6", 16'h001E);
    operand = 16'hF000; mode = 2'b10; #1;
    check("R6", 16'hFE00);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    operand = '0; amount = '0; mode = '0;
    test_zero_operand();
    test_zero_amount();
    sweep_mode(2'b00, "R1");
    sweep_mode(2'b01, "R2");
    sweep_mode(2'b10, "R3");
    sweep_mode(2'b11, "R4");
    test_asr_corners();
    test_comb();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule